// File: doc/BRIEF.md
# Opcode Exception Classifier

This unit looks at the first word of each fetched instruction, together with a few side-band facts supplied by the rest of the front end, and decides which exception, if any, that instruction must take. The side-band facts are: whether the main decoder recognised the word as legal, whether breakpoint mode is configured on, whether the instruction is a divide, and whether its divisor is zero. Full instruction decoding, stacking and bus sequencing are handled elsewhere. This block only names the cause and the vector.

Every classification is resolved by a fixed priority. The two emulation lines, with top nibble 1010 and 1111, come first. The permanently reserved trap words and the breakpoint range come next. A word the decoder rejected comes after those. A divide by zero is considered only for words that the decoder accepted. The result is registered, so it appears one clock after the strobe. It consists of a cause code, a vector number, the matching vector byte address, and a request for a breakpoint-acknowledge cycle.

Top module: `opx_classifier`

## Requirements
- R1: While reset is asserted and directly after it, out_valid, exc_cause, exc_vector, exc_vaddr and bkpt_ack are all zero.
- R2: The words 0x4AFA, 0x4AFB and 0x4AFC give cause 1 (illegal) with vector 4, whatever dec_legal, bkpt_en, is_div or div_zero say. The neighbouring word 0x4AFD with dec_legal high gives cause 0.
- R3: A word with bits 15..12 equal to 1010 gives cause 3 with vector 10. This holds regardless of every other input.
- R4: A word with bits 15..12 equal to 1111 gives cause 4 with vector 11. This holds regardless of every other input.
- R5: With bkpt_en high, the words 0x4848 through 0x484F give cause 2 with vector 4 and raise bkpt_ack. The words 0x4847 and 0x4850 are not in the range. With bkpt_en low, the range gets no special treatment and is classified by dec_legal alone, with bkpt_ack low.
- R6: For a word that is accepted by the decoder and not caught by R2 to R5, is_div high together with div_zero high gives cause 5 with vector 5. A divide with a non-zero divisor gives cause 0. If the decoder rejected the word, the result is illegal and not divide-by-zero.
- R7: Any other word with dec_legal low gives cause 1 with vector 4.
- R8: A word that triggers none of the above gives cause 0 with vector 0 and bkpt_ack low.
- R9: exc_vaddr always equals exc_vector multiplied by 4.
- R10: A classification appears on the outputs at the first rising edge after in_valid was sampled high, and out_valid is high for that cycle. A cycle with in_valid low drives out_valid low on the next edge and leaves exc_cause, exc_vector, exc_vaddr and bkpt_ack unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Opcode and side-band inputs are valid this cycle |
| opcode | input | OPW (16) | First instruction word |
| dec_legal | input | 1 | Main decoder accepted the word |
| bkpt_en | input | 1 | Breakpoint range classification enabled |
| is_div | input | 1 | Instruction is a signed or unsigned divide |
| div_zero | input | 1 | The divisor operand is zero |
| out_valid | output | 1 | Registered result is fresh this cycle |
| exc_cause | output | 3 | 0 none, 1 illegal, 2 breakpoint, 3 line 1010, 4 line 1111, 5 divide by zero |
| exc_vector | output | VEC_W (8) | Exception vector number |
| exc_vaddr | output | VEC_W+2 (10) | Vector byte address, vector number times 4 |
| bkpt_ack | output | 1 | Request for a breakpoint-acknowledge cycle |

## Verification
The only state in this block is one result register. If a priority branch or a detector picks the wrong cause, it shows up as a wrong cause/vector pair on the very next clock after the strobe. Because of this, each stimulus is compared exactly one edge after it is applied. If the hold path is broken, the result changes during idle cycles. If the vector map is broken, the vector and the address disagree with the cause. Both of these faults appear in the cycle that immediately follows.

// File: rtl/opx_pkg.sv
`timescale 1ns/1ps
package opx_pkg;

  typedef enum logic [2:0] {
    EXC_NONE    = 3'd0,
    EXC_ILLEGAL = 3'd1,
    EXC_BKPT    = 3'd2,
    EXC_LINE_A  = 3'd3,
    EXC_LINE_F  = 3'd4,
    EXC_DIVZ    = 3'd5
  } exc_cause_e;

  // Map a cause to its vector number; breakpoints share the illegal vector.
  function automatic int unsigned vec_of(exc_cause_e c,
                                         int unsigned v_ill,
                                         int unsigned v_divz,
                                         int unsigned v_la,
                                         int unsigned v_lf);
    case (c)
      EXC_ILLEGAL, EXC_BKPT: return v_ill;
      EXC_DIVZ:              return v_divz;
      EXC_LINE_A:            return v_la;
      EXC_LINE_F:            return v_lf;
      default:               return 0;
    endcase
  endfunction

endpackage

// File: rtl/opx_line_detect.sv
`timescale 1ns/1ps
// Flags the two emulation lines from the top nibble of the opcode.
module opx_line_detect #(
  parameter logic [3:0] NIB_A = 4'hA,
  parameter logic [3:0] NIB_F = 4'hF
) (
  input  logic [3:0] top_nib,
  output logic       line_a,
  output logic       line_f
);
  assign line_a = (top_nib == NIB_A);
  assign line_f = (top_nib == NIB_F);
endmodule

// File: rtl/opx_trap_detect.sv
`timescale 1ns/1ps
// Detects the reserved always-trap words and the breakpoint opcode range.
module opx_trap_detect #(
  parameter int unsigned      OPW         = 16,
  parameter logic [OPW-1:0]   RESV_BASE   = 16'h4AFA,
  parameter int unsigned      NRESV       = 3,
  parameter logic [OPW-1:0]   BKPT_BASE   = 16'h4848,
  parameter int unsigned      BKPT_SPAN_L = 3
) (
  input  logic [OPW-1:0] opcode,
  input  logic           bkpt_en,
  output logic           resv_hit,
  output logic           bkpt_hit
);
  logic [NRESV-1:0] resv_match;

  for (genvar i = 0; i < NRESV; i++) begin : g_resv
    assign resv_match[i] = (opcode == OPW'(RESV_BASE + OPW'(i)));
  end

  assign resv_hit = |resv_match;
  assign bkpt_hit = bkpt_en &&
                    (opcode[OPW-1:BKPT_SPAN_L] == BKPT_BASE[OPW-1:BKPT_SPAN_L]);
endmodule

// File: rtl/opx_resolve.sv
`timescale 1ns/1ps
// Fixed-priority selection of the exception cause.
module opx_resolve
  import opx_pkg::*;
(
  input  logic       line_a,
  input  logic       line_f,
  input  logic       resv_hit,
  input  logic       bkpt_hit,
  input  logic       dec_legal,
  input  logic       is_div,
  input  logic       div_zero,
  output exc_cause_e cause,
  output logic       ack_req
);
  always_comb begin
    ack_req = 1'b0;
    if (line_a)                      cause = EXC_LINE_A;
    else if (line_f)                 cause = EXC_LINE_F;
    else if (resv_hit)               cause = EXC_ILLEGAL;
    else if (bkpt_hit) begin
      cause   = EXC_BKPT;
      ack_req = 1'b1;
    end
    else if (!dec_legal)             cause = EXC_ILLEGAL;
    else if (is_div && div_zero)     cause = EXC_DIVZ;
    else                             cause = EXC_NONE;
  end
endmodule

// File: rtl/opx_classifier.sv
`timescale 1ns/1ps
module opx_classifier
  import opx_pkg::*;
#(
  parameter int unsigned OPW         = 16,
  parameter int unsigned VEC_W       = 8,
  parameter int unsigned VEC_ILLEGAL = 4,
  parameter int unsigned VEC_DIVZ    = 5,
  parameter int unsigned VEC_LINE_A  = 10,
  parameter int unsigned VEC_LINE_F  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OPW-1:0]   opcode,
  input  logic             dec_legal,
  input  logic             bkpt_en,
  input  logic             is_div,
  input  logic             div_zero,
  output logic             out_valid,
  output logic [2:0]       exc_cause,
  output logic [VEC_W-1:0] exc_vector,
  output logic [VEC_W+1:0] exc_vaddr,
  output logic             bkpt_ack
);
  localparam int unsigned AW = VEC_W + 2;

  // Named internal events, used by the assertions below.
  logic       line_a, line_f, resv_hit, bkpt_hit, ack_req;
  exc_cause_e cause_next, cause_q;
  logic [VEC_W-1:0] vec_next, vec_q;
  logic [AW-1:0]    addr_next, addr_q;
  logic             valid_q, ack_q;

  opx_line_detect u_line (
    .top_nib (opcode[OPW-1 -: 4]),
    .line_a  (line_a),
    .line_f  (line_f)
  );

  opx_trap_detect #(.OPW(OPW)) u_trap (
    .opcode   (opcode),
    .bkpt_en  (bkpt_en),
    .resv_hit (resv_hit),
    .bkpt_hit (bkpt_hit)
  );

  opx_resolve u_res (
    .line_a    (line_a),
    .line_f    (line_f),
    .resv_hit  (resv_hit),
    .bkpt_hit  (bkpt_hit),
    .dec_legal (dec_legal),
    .is_div    (is_div),
    .div_zero  (div_zero),
    .cause     (cause_next),
    .ack_req   (ack_req)
  );

  assign vec_next  = VEC_W'(vec_of(cause_next, VEC_ILLEGAL, VEC_DIVZ,
                                   VEC_LINE_A, VEC_LINE_F));
  assign addr_next = {vec_next, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cause_q <= EXC_NONE;
      vec_q   <= '0;
      addr_q  <= '0;
      ack_q   <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        cause_q <= cause_next;
        vec_q   <= vec_next;
        addr_q  <= addr_next;
        ack_q   <= ack_req;
      end
    end
  end

  assign out_valid  = valid_q;
  assign exc_cause  = cause_q;
  assign exc_vector = vec_q;
  assign exc_vaddr  = addr_q;
  assign bkpt_ack   = ack_q;

  // R10: result appears one edge after the strobe
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10: idle cycle holds the result
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(exc_cause) && $stable(exc_vector)
                   && $stable(bkpt_ack)));

  // R3
  a_r3_line_a: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && line_a) |=> (exc_cause == 3'd3 && exc_vector == VEC_W'(VEC_LINE_A)));

  // R4
  a_r4_line_f: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && line_f) |=> (exc_cause == 3'd4 && exc_vector == VEC_W'(VEC_LINE_F)));

  // R2
  a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && resv_hit) |=> (exc_cause == 3'd1 && exc_vector == VEC_W'(VEC_ILLEGAL)));

  // R5
  a_r5_ack_is_bkpt: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_ack |-> (exc_cause == 3'd2 && exc_vector == VEC_W'(VEC_ILLEGAL)));

  // R6
  a_r6_divz: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_legal && is_div && div_zero && !line_a && !line_f
     && !resv_hit && !bkpt_hit) |=> (exc_cause == 3'd5));

  // R8
  a_r8_none_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_cause == 3'd0) |-> (exc_vector == '0 && !bkpt_ack));

  // R9
  a_r9_addr_x4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vaddr[1:0] == 2'b00 && exc_vaddr[AW-1:2] == exc_vector);
endmodule

// File: tb/tb_opx_classifier.sv
`timescale 1ns/1ps
module tb_opx_classifier;
  logic        clk = 1'b0;
  logic        rst_n, in_valid, dec_legal, bkpt_en, is_div, div_zero;
  logic [15:0] opcode;
  logic        out_valid, bkpt_ack;
  logic [2:0]  exc_cause;
  logic [7:0]  exc_vector;
  logic [9:0]  exc_vaddr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  opx_classifier dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .dec_legal(dec_legal), .bkpt_en(bkpt_en), .is_div(is_div),
    .div_zero(div_zero), .out_valid(out_valid), .exc_cause(exc_cause),
    .exc_vector(exc_vector), .exc_vaddr(exc_vaddr), .bkpt_ack(bkpt_ack)
  );

  // {opcode, legal, bkpt_en, is_div, div_zero, cause, vector, ack}
  localparam int NV = 20;
  localparam logic [31:0] TBL [NV] = '{
    {16'h4AFA, 4'b1000, 3'd1, 8'd4,  1'b0},  // R2
    {16'h4AFB, 4'b0000, 3'd1, 8'd4,  1'b0},  // R2
    {16'h4AFC, 4'b1100, 3'd1, 8'd4,  1'b0},  // R2
    {16'h4AFD, 4'b1000, 3'd0, 8'd0,  1'b0},  // R2 boundary
    {16'hA000, 4'b1000, 3'd3, 8'd10, 1'b0},  // R3
    {16'hAFFF, 4'b0011, 3'd3, 8'd10, 1'b0},  // R3
    {16'hF000, 4'b1000, 3'd4, 8'd11, 1'b0},  // R4
    {16'hFFFF, 4'b0111, 3'd4, 8'd11, 1'b0},  // R4
    {16'h4848, 4'b1100, 3'd2, 8'd4,  1'b1},  // R5
    {16'h484F, 4'b0100, 3'd2, 8'd4,  1'b1},  // R5
    {16'h4850, 4'b1100, 3'd0, 8'd0,  1'b0},  // R5 boundary
    {16'h4847, 4'b1100, 3'd0, 8'd0,  1'b0},  // R5 boundary
    {16'h484C, 4'b1000, 3'd0, 8'd0,  1'b0},  // R5 disabled
    {16'h484C, 4'b0000, 3'd1, 8'd4,  1'b0},  // R5 disabled
    {16'h81C1, 4'b1011, 3'd5, 8'd5,  1'b0},  // R6
    {16'h81C1, 4'b1010, 3'd0, 8'd0,  1'b0},  // R6
    {16'h80C0, 4'b0011, 3'd1, 8'd4,  1'b0},  // R6 / R7
    {16'h1234, 4'b0000, 3'd1, 8'd4,  1'b0},  // R7
    {16'h1234, 4'b1001, 3'd0, 8'd0,  1'b0},  // R8
    {16'h4AFA, 4'b1011, 3'd1, 8'd4,  1'b0}   // R2 over divide
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] row);
    opcode    = row[31:16];
    dec_legal = row[15];
    bkpt_en   = row[14];
    is_div    = row[13];
    div_zero  = row[12];
    in_valid  = 1'b1;
  endtask

  initial begin
    rst_n = 0; in_valid = 0; opcode = 16'h0; dec_legal = 0;
    bkpt_en = 0; is_div = 0; div_zero = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid",  32'(out_valid), 0);
    chk("R1 cause",  32'(exc_cause), 0);
    chk("R1 vector", 32'(exc_vector), 0);
    chk("R1 vaddr",  32'(exc_vaddr), 0);
    chk("R1 ack",    32'(bkpt_ack), 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(TBL[i]);
      @(posedge clk); #1;
      chk($sformatf("R10 valid row %0d", i), 32'(out_valid), 1);
      chk($sformatf("R2-R8 cause row %0d", i), 32'(exc_cause), 32'(TBL[i][11:9]));
      chk($sformatf("cause vector row %0d", i), 32'(exc_vector), 32'(TBL[i][8:1]));
      chk($sformatf("R5 ack row %0d", i), 32'(bkpt_ack), 32'(TBL[i][0]));
      chk($sformatf("R9 vaddr row %0d", i), 32'(exc_vaddr), 32'(TBL[i][8:1]) * 4);
    end

    // R10 idle: a different word without strobe must not change the result
    @(negedge clk);
    in_valid = 0; opcode = 16'hF000; dec_legal = 1; is_div = 0; div_zero = 0;
    @(posedge clk); #1;
    chk("R10 idle valid",  32'(out_valid), 0);
    chk("R10 idle cause",  32'(exc_cause), 1);
    chk("R10 idle vector", 32'(exc_vector), 4);
    chk("R10 idle vaddr",  32'(exc_vaddr), 16);
    @(posedge clk); #1;
    chk("R10 idle hold 2", 32'(exc_cause), 1);

    // R5 ack then idle hold of ack
    @(negedge clk);
    opcode = 16'h484B; bkpt_en = 1; dec_legal = 1; in_valid = 1;
    @(posedge clk); #1;
    chk("R5 ack mid", 32'(bkpt_ack), 1);
    @(negedge clk); in_valid = 0;
    @(posedge clk); #1;
    chk("R10 ack held", 32'(bkpt_ack), 1);

    // Line F after idle
    @(negedge clk);
    opcode = 16'hF123; in_valid = 1;
    @(posedge clk); #1;
    chk("R4 after idle", 32'(exc_cause), 4);
    chk("R5 ack cleared", 32'(bkpt_ack), 0);
    chk("R9 vaddr line F", 32'(exc_vaddr), 44);

    // R1 reset mid-run
    @(negedge clk); in_valid = 0; rst_n = 0;
    @(posedge clk); #1;
    chk("R1 mid cause",  32'(exc_cause), 0);
    chk("R1 mid vector", 32'(exc_vector), 0);
    chk("R1 mid vaddr",  32'(exc_vaddr), 0);
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule